// File: doc/BRIEF.md
# MDIO Management Master

This block runs Clause 22 management transactions from a system-clock domain to an external PHY over a two-wire MDC/MDIO link. Software programs a self-control register with a clock divisor and an optional preamble-drop flag. For a write it loads the 16-bit payload into the data register, then writes a command word holding a read or write flag, the PHY address and the register number. The block derives MDC, shifts the frame out and, for reads, releases the line and gathers the PHY's reply back into the data register.

A status bit shows that a transaction is running. Software polls it and reads the data register once it drops. The self-control register also carries a soft reset bit. Writing it aborts any transaction, and the hardware clears the bit after a fixed number of cycles.

The sequencer has four states:
- IDLE waits for an accepted command. IDLE→LOW happens on a valid command.
- LOW holds MDC low for one half-period with the current bit driven. LOW→HIGH happens when the half-period count expires, and read data is sampled on that edge.
- HIGH holds MDC high. HIGH→LOW advances to the next bit. HIGH→IDLE follows the last frame bit.
- SRST counts out the soft reset. Any state goes to SRST on a soft-reset write, and SRST→IDLE happens after `SRST_CYCLES` cycles.

Top module: `mdio_master`

The register bus is 16 bits wide and decodes four word addresses:
- 0: self-control
- 1: command
- 2: data
- 3: status

## Requirements
- R1: A write to address 1 starts a transaction only when exactly one of bit 15 (read) and bit 14 (write) is set. Bits 9:5 carry the PHY address and bits 4:0 the register number. A word with both flags set or neither flag set starts nothing.
- R2: Status bit 0 (busy) reads 1 from the cycle after an accepted command until the last MDC high phase of the frame ends.
- R3: A write frame on MDIO, MSB first, is: 32 ones of preamble, start 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then the 16 data bits. The output enable is asserted for every bit.
- R4: A read frame uses opcode 10. The output enable drops for the two turnaround bits and the 16 data bits. The bits sampled on MDIO at the MDC rising edges of the data field land MSB first in the data register, which is readable at address 2 once busy clears. The output enable is low whenever the block is idle.
- R5: Self-control bits 15:9 hold the divisor minus one. Each MDC half-period lasts ceil(divisor/2) system clocks. MDC is low while idle.
- R6: Self-control bit 8 set drops the preamble, leaving a 32-bit frame with 32 MDC pulses instead of 64.
- R7: MDIO output and output enable change only on the clock edge where MDC falls or while MDC is low. They stay stable throughout each MDC high phase.
- R8: While busy, writes to the command register and the data register are ignored. The running frame, the stored command word and the data register are unchanged.
- R9: Writing self-control with bit 0 set aborts any transaction. Busy drops and MDC returns low. Bit 0 reads 1 until `SRST_CYCLES` cycles later, then reads 0. The divisor and preamble fields keep the values of that write.
- R10: After reset, self-control, status, MDC and the output enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The bench walks reads and writes across divisor values, including divisor 1, where a half-period is a single clock. It also covers both preamble settings. A wrong half-period rounding would show up as a wrong MDC high-cycle total. A wrong field order, or an off-by-one on the turnaround, would corrupt the captured frame or shift the read data by one bit. The bench also checks the corner cases below:
- A command with both flags set, and one with neither, must start nothing.
- A command and a data write issued mid-frame must not restart or corrupt the frame.
- A soft reset mid-frame must stop MDC at once, clear its own bit on time, keep the divisor field, and leave the block usable.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_SRST = 2'd3
    } mdio_state_t;

    localparam logic [1:0] ADDR_SELF = 2'd0;
    localparam logic [1:0] ADDR_CMD  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CMD_RD_BIT   = 15;
    localparam int CMD_WR_BIT   = 14;
    localparam int SELF_DIV_LSB = 9;
    localparam int SELF_SUP_BIT = 8;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    input  logic             busy,
    input  logic             srst_active,
    input  logic             cap_en,
    input  logic             cap_bit,
    output logic [DIV_W-1:0] div_m1,
    output logic             supp,
    output logic             start,
    output logic             start_read,
    output logic [4:0]       phy,
    output logic [4:0]       regnum,
    output logic [15:0]      wr_data,
    output logic             srst_req
);
    localparam int DIV_MSB = SELF_DIV_LSB + DIV_W - 1;

    logic [DIV_W-1:0] div_q;
    logic             supp_q;
    logic [15:0]      data_q;
    logic [15:0]      cmd_q;
    logic             accept;

    always_comb begin
        accept     = !busy && !srst_active;
        start      = reg_wr && (reg_addr == ADDR_CMD) && accept &&
                     (reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT]);
        start_read = reg_wdata[CMD_RD_BIT];
        phy        = reg_wdata[9:5];
        regnum     = reg_wdata[4:0];
        srst_req   = reg_wr && (reg_addr == ADDR_SELF) && reg_wdata[0];
        div_m1     = div_q;
        supp       = supp_q;
        wr_data    = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            supp_q <= 1'b0;
            data_q <= '0;
            cmd_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_SELF) begin
                div_q  <= reg_wdata[DIV_MSB:SELF_DIV_LSB];
                supp_q <= reg_wdata[SELF_SUP_BIT];
            end
            if (reg_wr && reg_addr == ADDR_DATA && accept)
                data_q <= reg_wdata;
            else if (cap_en)
                data_q <= {data_q[14:0], cap_bit};
            if (start)
                cmd_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_SELF: begin
                reg_rdata[DIV_MSB:SELF_DIV_LSB] = div_q;
                reg_rdata[SELF_SUP_BIT]         = supp_q;
                reg_rdata[0]                    = srst_active;
            end
            ADDR_CMD:  reg_rdata = cmd_q;
            ADDR_DATA: reg_rdata = data_q;
            ADDR_STAT: reg_rdata[0] = busy;
        endcase
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int SRST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             supp,
    input  logic             start,
    input  logic             start_read,
    input  logic [4:0]       phy,
    input  logic [4:0]       regnum,
    input  logic [15:0]      wr_data,
    input  logic             srst_req,
    input  logic             mdio_in,
    output logic             mdc,
    output logic             mdio_out,
    output logic             mdio_oe,
    output logic             busy,
    output logic             srst_active,
    output logic             cap_en,
    output logic             cap_bit
);
    localparam int SR_W  = $clog2(SRST_CYCLES) + 1;
    localparam int CNT_W = (DIV_W + 1 > SR_W) ? DIV_W + 1 : SR_W;

    mdio_state_t      state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic [5:0]       idx;
    logic [63:0]      frame_q;
    logic             is_rd;
    logic             half_done;

    always_comb begin
        half      = CNT_W'((CNT_W'(div_m1) + CNT_W'(2)) >> 1);
        half_done = (cnt == half - CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            frame_q <= '0;
            is_rd   <= 1'b0;
        end else if (srst_req) begin
            state <= ST_SRST;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state   <= ST_LOW;
                    cnt     <= '0;
                    idx     <= supp ? 6'(PRE_BITS) : 6'd0;
                    is_rd   <= start_read;
                    frame_q <= {32'hFFFF_FFFF, 2'b01,
                                start_read ? 2'b10 : 2'b01, phy, regnum,
                                start_read ? 2'b11 : 2'b10,
                                start_read ? 16'hFFFF : wr_data};
                end
                ST_LOW: begin
                    if (half_done) begin
                        cnt   <= '0;
                        state <= ST_HIGH;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (half_done) begin
                        cnt <= '0;
                        if (idx == 6'(FRAME_BITS - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            idx   <= idx + 6'd1;
                            state <= ST_LOW;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SRST: begin
                    if (cnt == CNT_W'(SRST_CYCLES - 1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        busy        = (state == ST_LOW) || (state == ST_HIGH);
        srst_active = (state == ST_SRST);
        mdc         = (state == ST_HIGH);
        mdio_out    = busy ? frame_q[~idx] : 1'b0;
        mdio_oe     = busy && !(is_rd && idx >= 6'(TA_IDX));
        cap_en      = (state == ST_LOW) && half_done && is_rd &&
                      (idx >= 6'(DATA_IDX));
        cap_bit     = mdio_in;
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int DIV_W       = 7,
    parameter int SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic [DIV_W-1:0] div_m1;
    logic             supp;
    logic             start;
    logic             start_read;
    logic [4:0]       phy;
    logic [4:0]       regnum;
    logic [15:0]      wr_data;
    logic             srst_req;
    logic             busy;
    logic             srst_active;
    logic             cap_en;
    logic             cap_bit;

    mdio_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .srst_active(srst_active), .cap_en(cap_en), .cap_bit(cap_bit),
        .div_m1(div_m1), .supp(supp), .start(start),
        .start_read(start_read), .phy(phy), .regnum(regnum),
        .wr_data(wr_data), .srst_req(srst_req)
    );

    mdio_engine #(.DIV_W(DIV_W), .SRST_CYCLES(SRST_CYCLES)) u_engine (
        .clk(clk), .rst_n(rst_n), .div_m1(div_m1), .supp(supp),
        .start(start), .start_read(start_read), .phy(phy),
        .regnum(regnum), .wr_data(wr_data), .srst_req(srst_req),
        .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .busy(busy), .srst_active(srst_active),
        .cap_en(cap_en), .cap_bit(cap_bit)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic srst_active,
    input logic mdc,
    input logic mdio_out,
    input logic mdio_oe
);
    assert_mdc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    assert_oe_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mdio_oe) && busy) |-> !mdc);

    assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !srst_active) |-> $past(mdc));

    assert_srst_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_active) |-> (!mdc && !mdio_oe));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .srst_active(srst_active),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    import mdio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int fails  = 0;

    int          rises = 0;
    int          oe_bits = 0;
    int          hi_cyc = 0;
    int          offs = 0;
    logic [63:0] cap = '0;
    logic [15:0] rd_val = '0;

    always #4 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always @(posedge mdc) begin
        rises = rises + 1;
        if (mdio_oe) begin
            cap     = {cap[62:0], mdio_out};
            oe_bits = oe_bits + 1;
        end
    end

    always @(negedge mdc) begin
        int n;
        n = rises + offs;
        if (n >= 48 && n < 64) mdio_in = rd_val[63 - n];
        else mdio_in = 1'b1;
    end

    always @(negedge clk) if (mdc) hi_cyc = hi_cyc + 1;

    // {read, preamble-drop, divisor-1, phy, reg, value}
    localparam int NV = 6;
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 1'b0, 7'd3, 5'h01, 5'h00, 16'hA5C3},
        {1'b1, 1'b0, 7'd1, 5'h1F, 5'h01, 16'h796D},
        {1'b0, 1'b1, 7'd0, 5'h15, 5'h1F, 16'h0001},
        {1'b1, 1'b1, 7'd4, 5'h02, 5'h04, 16'h8000},
        {1'b0, 1'b0, 7'd6, 5'h0A, 5'h11, 16'hFFFF},
        {1'b1, 1'b0, 7'd0, 5'h1E, 5'h02, 16'h0000}
    };

    task automatic check(input logic ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int k = 0; k < 5000; k++) begin
            reg_read(ADDR_STAT, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic clear_mon(input logic supp, input logic [15:0] v);
        rises = 0; oe_bits = 0; hi_cyc = 0; cap = '0;
        offs = supp ? 32 : 0; rd_val = v;
    endtask

    function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] v);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r,
                rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : v};
    endfunction

    task automatic run_txn(input logic [34:0] e);
        logic        rd, supp;
        logic [6:0]  dv;
        logic [4:0]  p, r;
        logic [15:0] v, s;
        logic [63:0] ec, mask;
        int nbits, eoe, half;
        {rd, supp, dv, p, r, v} = e;
        nbits = supp ? 32 : 64;
        eoe   = rd ? nbits - 18 : nbits;
        half  = (dv + 2) / 2;
        reg_write(ADDR_SELF, {dv, supp, 8'h00});
        if (!rd) reg_write(ADDR_DATA, v);
        clear_mon(supp, v);
        reg_write(ADDR_CMD, {rd, ~rd, 4'b0000, p, r});
        reg_read(ADDR_STAT, s);
        check(s[0] == 1'b1, "R2 busy set after command", 64'(s[0]), 64'd1);
        wait_idle();
        check(rises == nbits, "R6 MDC pulse count", 64'(rises), 64'(nbits));
        check(oe_bits == eoe, "R4 driven bit count", 64'(oe_bits), 64'(eoe));
        ec   = rd ? (exp_frame(rd, p, r, v) >> 18) : exp_frame(rd, p, r, v);
        mask = (eoe >= 64) ? '1 : ((64'd1 << eoe) - 64'd1);
        check((cap & mask) == (ec & mask), "R3 frame bits on MDIO",
              cap & mask, ec & mask);
        check(hi_cyc == nbits * half, "R5 MDC high cycles",
              64'(hi_cyc), 64'(nbits * half));
        if (rd) begin
            reg_read(ADDR_DATA, s);
            check(s == v, "R4 read data captured", 64'(s), 64'(v));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        reg_read(ADDR_SELF, d);
        check(d == 16'h0, "R10 self-control after reset", 64'(d), 64'h0);
        reg_read(ADDR_STAT, d);
        check(d == 16'h0, "R10 status after reset", 64'(d), 64'h0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 MDC and OE low",
              64'({mdc, mdio_oe}), 64'h0);

        for (int i = 0; i < NV; i++) run_txn(VEC[i]);

        // R1 both flags and neither flag start nothing
        reg_write(ADDR_SELF, {7'd1, 1'b0, 8'h00});
        clear_mon(1'b0, 16'h0);
        reg_write(ADDR_CMD, 16'hC000 | 16'h0043);
        reg_read(ADDR_STAT, d);
        check(d[0] == 1'b0, "R1 both flags ignored", 64'(d[0]), 64'd0);
        reg_write(ADDR_CMD, 16'h0043);
        repeat (20) @(negedge clk);
        reg_read(ADDR_STAT, d);
        check(d[0] == 1'b0 && rises == 0, "R1 no flag ignored",
              64'(rises), 64'd0);

        // R8 command and data writes during busy
        reg_write(ADDR_SELF, {7'd3, 1'b0, 8'h00});
        reg_write(ADDR_DATA, 16'h1234);
        clear_mon(1'b0, 16'h0);
        reg_write(ADDR_CMD, {2'b01, 4'b0000, 5'h03, 5'h05});
        repeat (20) @(negedge clk);
        reg_write(ADDR_CMD, {2'b10, 4'b0000, 5'h07, 5'h09});
        reg_write(ADDR_DATA, 16'hBEEF);
        wait_idle();
        check(cap == exp_frame(1'b0, 5'h03, 5'h05, 16'h1234),
              "R8 running frame untouched", cap,
              exp_frame(1'b0, 5'h03, 5'h05, 16'h1234));
        reg_read(ADDR_DATA, d);
        check(d == 16'h1234, "R8 data register kept", 64'(d), 64'h1234);
        reg_read(ADDR_CMD, d);
        check(d == {2'b01, 4'b0000, 5'h03, 5'h05}, "R8 command word kept",
              64'(d), 64'({2'b01, 4'b0000, 5'h03, 5'h05}));

        // R9 soft reset mid-frame
        reg_write(ADDR_SELF, {7'd5, 1'b0, 8'h00});
        clear_mon(1'b0, 16'h0);
        reg_write(ADDR_CMD, {2'b01, 4'b0000, 5'h04, 5'h06});
        repeat (30) @(negedge clk);
        reg_write(ADDR_SELF, {7'd5, 1'b0, 7'h00, 1'b1});
        reg_read(ADDR_SELF, d);
        check(d[0] == 1'b1 && d[15:9] == 7'd5, "R9 reset bit set, divisor kept",
              64'(d), 64'({7'd5, 8'h00, 1'b1}));
        reg_read(ADDR_STAT, d);
        check(d[0] == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0,
              "R9 transaction aborted", 64'({d[0], mdc, mdio_oe}), 64'h0);
        repeat (8) @(negedge clk);
        reg_read(ADDR_SELF, d);
        check(d == {7'd5, 9'h000}, "R9 reset bit self-cleared",
              64'(d), 64'({7'd5, 9'h000}));
        run_txn(VEC[1]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule